// File: doc/BRIEF.md
# Sprite DMA Slot Scheduler

This block decides, one video line at a time, when each of eight hardware sprites may read a word from memory. It does the reading itself and hands every returned word to the sprite display logic. The beam counters drive the scheduler. It makes a slot decision three cycles before the memory access and parks a tagged slot code in a short circular pipeline. When that code comes out of the pipeline, the block issues one 16-bit read at the sprite's pointer and advances the pointer by two. On the next cycle it presents the returned word together with the sprite number and the kind of load.

Each sprite has a four-cycle window in a fixed order. In that window, a first and a second fetch may fall on the even sub-cycles. The block keeps a vertical start line, a vertical stop line and an active flag for each sprite:

- While a sprite is active, its two fetches carry image data.
- On its stop line and on the vertical-blank-end line, the same two fetches reload the position and control words.
- A control-word load makes the sprite re-evaluate its start and stop lines on the current line, so a sprite can restart at once.

Top module: `sprite_slot_sched`

## Requirements
- R1: The first fetch of sprite n (n = 0..7) drives `mem_req` while `hpos` equals 25+4n, and its second fetch drives it while `hpos` equals 27+4n. The loaded word appears on `load_*` with `load_valid` in the following cycle.
- R2: A fetch happens only if a decision made three cycles before it (at `hpos` = fetch position - 3) saw `dma_en` high and `hpos` below `fetch_limit`. Example: with the limit at 28, sprite 0 makes both fetches and sprite 1 makes only its first.
- R3: No fetch is scheduled on a line where `vpos` is below `vbend_line`, or where `last_line` is high.
- R4: On the line where `vpos` equals a sprite's start line, the sprite becomes active and fetches two data words on every line up to its stop line. On the stop line and on the `vbend_line` line, it makes a position fetch and then a control fetch.
- R5: `load_kind` encodes the load as 0 = position, 1 = control, 2 = first data word, 3 = second data word. Bits [8:0] of a position word set the start line, and bits [8:0] of a control word set the stop line; the other bits do not affect scheduling. `load_word` is the word returned by memory.
- R6: A control load clears the active flag, then sets it again if `vpos` equals the start line and the new stop line differs from `vpos`. A sprite whose new start line is the current line therefore fetches data from the next line on.
- R7: After its position and control pair, an inactive sprite makes no further fetch until a later start line or `vbend_line`.
- R8: Each fetch reads at the sprite's pointer, and each completed fetch adds 2 to that pointer. A low-half pointer write loads bits [15:0] with bit 0 forced to zero. A high-half write loads the bits above bit 15.
- R9: A fetch cycle with `mem_ready` low still drives `mem_req`, but it produces no load and leaves the pointer unchanged.
- R10: During and just after reset, `mem_req`, `load_valid` and `slot_clash` are low and the slot pipeline is empty.
- R11: `slot_clash` pulses for one cycle after a slot code is written into a pipeline entry that is still occupied. It stays low while `hpos` advances by one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one beam cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos | input | 9 | Horizontal beam position |
| vpos | input | 9 | Vertical beam line |
| vbend_line | input | 9 | Line where vertical blank ends |
| last_line | input | 1 | Current line is the last line of the field |
| dma_en | input | 1 | Global sprite DMA enable |
| fetch_limit | input | 9 | Horizontal position from which no slot is decided |
| ptr_wr | input | 1 | Pointer write strobe |
| ptr_wr_id | input | 3 | Sprite whose pointer is written |
| ptr_wr_hi | input | 1 | 1 writes the high half, 0 the low half |
| ptr_wr_data | input | 16 | Pointer write data |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | 21 | Read byte address |
| mem_ready | input | 1 | Read accepted, data valid this cycle |
| mem_rdata | input | 16 | Read data |
| load_valid | output | 1 | A word was loaded |
| load_sprite | output | 3 | Sprite number of the load |
| load_kind | output | 2 | Load kind (R5 encoding) |
| load_word | output | 16 | Loaded word |
| slot_clash | output | 1 | Pipeline entry collision pulse |

## Verification
The assertions check on every cycle that requests fall only on even sub-cycles of the slot windows and that addresses are even. They also check that every accepted request is followed by exactly one load, and that each request traces back three cycles to a decision allowed by `dma_en`, the horizontal limit, the blank-end line and the last-line flag. Only the bench scenarios can show which sprite loads which kind of word on which line: start and stop sequencing, restart through control re-evaluation, the silence after a stop, and pointers left unchanged by refused reads.

// File: rtl/sprite_slot_sched.sv
module sprite_slot_sched #(
  parameter int NUM_SPR    = 8,
  parameter int BEAM_W     = 9,
  parameter int PTR_W      = 21,
  parameter int FIRST_SLOT = 25,
  parameter int LEAD       = 3,
  parameter int PIPE_LEN   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BEAM_W-1:0] hpos,
  input  logic [BEAM_W-1:0] vpos,
  input  logic [BEAM_W-1:0] vbend_line,
  input  logic              last_line,
  input  logic              dma_en,
  input  logic [BEAM_W-1:0] fetch_limit,
  input  logic              ptr_wr,
  input  logic [2:0]        ptr_wr_id,
  input  logic              ptr_wr_hi,
  input  logic [15:0]       ptr_wr_data,
  output logic              mem_req,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic              mem_ready,
  input  logic [15:0]       mem_rdata,
  output logic              load_valid,
  output logic [2:0]        load_sprite,
  output logic [1:0]        load_kind,
  output logic [15:0]       load_word,
  output logic              slot_clash
);
  localparam int ID_W      = 3;
  localparam int PIPE_AW   = $clog2(PIPE_LEN);
  localparam int WIN_START = FIRST_SLOT - LEAD;
  localparam int WIN_END   = WIN_START + 4 * NUM_SPR;
  localparam logic [1:0] K_POS = 2'd0;
  localparam logic [1:0] K_CTL = 2'd1;

  logic [7:0]        pipe   [PIPE_LEN];
  logic [NUM_SPR-1:0] active;
  logic [1:0]        cyc    [NUM_SPR];
  logic [BEAM_W-1:0] vstart [NUM_SPR];
  logic [BEAM_W-1:0] vstop  [NUM_SPR];
  logic [PTR_W-1:0]  ptr    [NUM_SPR];

  wire              line_ok  = (vpos >= vbend_line) && !last_line;
  wire [BEAM_W-1:0] rel      = hpos - BEAM_W'(WIN_START);
  wire              in_win   = (hpos >= BEAM_W'(WIN_START)) && (hpos < BEAM_W'(WIN_END));
  wire [ID_W-1:0]   dec_id   = rel[ID_W+1:2];
  wire [1:0]        sub      = rel[1:0];
  wire              dec_slot = in_win && line_ok && !sub[0];

  logic       dec_act;
  logic [1:0] dec_cyc, dec_cyc_n;
  logic       dec_emit;

  always_comb begin
    dec_act = active[dec_id];
    dec_cyc = cyc[dec_id];
    if (sub == 2'd0) begin
      if (dec_cyc == 2'd0 && dec_act) dec_cyc = 2'd1;
      if (vpos == vstart[dec_id]) begin
        dec_act = 1'b1;
        dec_cyc = 2'd1;
      end
      if (vpos == vstop[dec_id] || vpos == vbend_line) begin
        dec_act = 1'b0;
        dec_cyc = 2'd1;
      end
    end
    dec_emit  = dec_slot && (dec_cyc != 2'd0) && dma_en && (hpos < fetch_limit);
    dec_cyc_n = dec_cyc;
    if (dec_cyc == 2'd2)      dec_cyc_n = dec_act ? 2'd1 : 2'd0;
    else if (dec_cyc == 2'd1) dec_cyc_n = 2'd2;
  end

  wire [7:0] dec_code = {3'b010, dec_act, dec_cyc == 2'd2, dec_id};

  wire [PIPE_AW-1:0] wr_idx  = hpos[PIPE_AW-1:0];
  wire [PIPE_AW-1:0] rd_idx  = hpos[PIPE_AW-1:0] - PIPE_AW'(LEAD);
  wire [7:0]         rd_code = pipe[rd_idx];
  wire               fetch   = rd_code[7:5] == 3'b010;
  wire [ID_W-1:0]    f_id    = rd_code[ID_W-1:0];
  wire [1:0]         f_kind  = rd_code[4:3];
  wire               done    = fetch && mem_ready;
  wire [BEAM_W-1:0]  word_v  = mem_rdata[BEAM_W-1:0];
  wire               ctl_act = line_ok && (vpos == vstart[f_id]) && (vpos != word_v);

  assign mem_req  = fetch;
  assign mem_addr = ptr[f_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < PIPE_LEN; e++) pipe[e] <= '0;
      for (int i = 0; i < NUM_SPR; i++) begin
        active[i] <= 1'b0;
        cyc[i]    <= '0;
        vstart[i] <= '0;
        vstop[i]  <= '0;
        ptr[i]    <= '0;
      end
      load_valid  <= 1'b0;
      load_sprite <= '0;
      load_kind   <= '0;
      load_word   <= '0;
      slot_clash  <= 1'b0;
    end else begin
      slot_clash  <= dec_emit && (pipe[wr_idx] != 8'd0);
      if (fetch)    pipe[rd_idx] <= 8'd0;
      if (dec_emit) pipe[wr_idx] <= dec_code;
      load_valid  <= done;
      load_sprite <= f_id;
      load_kind   <= f_kind;
      load_word   <= mem_rdata;
      for (int i = 0; i < NUM_SPR; i++) begin
        if (done && f_id == ID_W'(i)) begin
          ptr[i] <= ptr[i] + PTR_W'(2);
          if (f_kind == K_POS) vstart[i] <= word_v;
          if (f_kind == K_CTL) begin
            vstop[i]  <= word_v;
            active[i] <= ctl_act;
          end
        end
        if (dec_slot && dec_id == ID_W'(i)) begin
          active[i] <= dec_act;
          cyc[i]    <= dec_cyc_n;
        end
        if (ptr_wr && ptr_wr_id == ID_W'(i)) begin
          if (ptr_wr_hi) ptr[i][PTR_W-1:16] <= ptr_wr_data[PTR_W-17:0];
          else           ptr[i][15:0]       <= {ptr_wr_data[15:1], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/sprite_slot_sched_chk.sv
module sprite_slot_sched_chk #(
  parameter int NUM_SPR    = 8,
  parameter int BEAM_W     = 9,
  parameter int PTR_W      = 21,
  parameter int FIRST_SLOT = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BEAM_W-1:0] hpos,
  input logic [BEAM_W-1:0] vpos,
  input logic [BEAM_W-1:0] vbend_line,
  input logic [BEAM_W-1:0] fetch_limit,
  input logic              last_line,
  input logic              dma_en,
  input logic              mem_req,
  input logic              mem_ready,
  input logic [PTR_W-1:0]  mem_addr,
  input logic              load_valid
);
  localparam int SLOT_END = FIRST_SLOT + 4 * NUM_SPR;
  wire first_odd = 1'(FIRST_SLOT % 2);
  wire in_phase  = (hpos >= BEAM_W'(FIRST_SLOT)) && (hpos < BEAM_W'(SLOT_END)) && (hpos[0] == first_odd);

  assert_slot_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> in_phase);

  assert_load_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> load_valid);

  assert_no_load_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_ready) |=> !load_valid);

  assert_decision_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($past(dma_en, 3) && ($past(hpos, 3) < $past(fetch_limit, 3))));

  assert_line_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (($past(vpos, 3) >= $past(vbend_line, 3)) && !$past(last_line, 3)));

  assert_even_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);
endmodule

bind sprite_slot_sched sprite_slot_sched_chk #(
  .NUM_SPR(NUM_SPR), .BEAM_W(BEAM_W), .PTR_W(PTR_W), .FIRST_SLOT(FIRST_SLOT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .vbend_line(vbend_line),
  .fetch_limit(fetch_limit), .last_line(last_line), .dma_en(dma_en),
  .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr), .load_valid(load_valid)
);

// File: tb/tb_sprite_slot_sched.sv
module tb_sprite_slot_sched;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 64;
  localparam int FIRST = 25;

  logic clk = 0, rst_n = 0;
  logic [8:0] hpos = 0, vpos = 0, vbend_line = 9'd4, fetch_limit = 9'd300;
  logic last_line = 0, dma_en = 1, ptr_wr = 0, ptr_wr_hi = 0, mem_ready = 1;
  logic [2:0] ptr_wr_id = 0;
  logic [15:0] ptr_wr_data = 0;
  logic mem_req, load_valid, slot_clash;
  logic [20:0] mem_addr;
  logic [15:0] mem_rdata, load_word;
  logic [2:0] load_sprite;
  logic [1:0] load_kind;

  logic [15:0] mem [1024];
  assign mem_rdata = mem[mem_addr[10:1]];

  always #(CLK_PERIOD/2) clk = ~clk;

  sprite_slot_sched dut (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .vbend_line(vbend_line),
    .last_line(last_line), .dma_en(dma_en), .fetch_limit(fetch_limit),
    .ptr_wr(ptr_wr), .ptr_wr_id(ptr_wr_id), .ptr_wr_hi(ptr_wr_hi), .ptr_wr_data(ptr_wr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .load_valid(load_valid), .load_sprite(load_sprite), .load_kind(load_kind),
    .load_word(load_word), .slot_clash(slot_clash)
  );

  typedef struct { int id; int kind; int word; int addr; int h; string tag; } item_t;
  item_t expq[$];
  int addrq[$];
  int bp[8];
  int checks = 0, failures = 0, req_cnt = 0, clash_seen = 0, stray_clash = 0;
  bit ignore = 0, clash_ok = 0, finished = 0;
  string cur_req = "R7";
  item_t it;
  int got_a;

  always @(negedge clk) begin
    if (rst_n) begin
      if (slot_clash) begin
        if (clash_ok) clash_seen++;
        else stray_clash++;
      end
      if (!ignore) begin
        if (mem_req) req_cnt++;
        if (mem_req && mem_ready) addrq.push_back(int'(mem_addr));
        if (load_valid) begin
          checks++;
          if (expq.size() == 0) begin
            failures++;
            $display("FAIL %s unexpected load sprite=%0d kind=%0d word=%h at h=%0d, expected none",
                     cur_req, load_sprite, load_kind, load_word, hpos);
          end else begin
            it = expq.pop_front();
            got_a = (addrq.size() > 0) ? addrq.pop_front() : -1;
            if (load_sprite != it.id || load_kind != it.kind || load_word != it.word[15:0] ||
                hpos != it.h || got_a != it.addr) begin
              failures++;
              $display("FAIL %s load spr=%0d kind=%0d word=%h h=%0d addr=%h, expected spr=%0d kind=%0d word=%h h=%0d addr=%h",
                       it.tag, load_sprite, load_kind, load_word, hpos, got_a,
                       it.id, it.kind, it.word, it.h, it.addr);
            end
          end
        end
      end
    end
  end

  task automatic expect_fetch(int n, int kind, int second, string tag);
    item_t x;
    x.id = n; x.kind = kind; x.addr = bp[n];
    x.word = mem[(bp[n] >> 1) & 1023];
    x.h = FIRST + 4*n + (second ? 2 : 0) + 1;
    x.tag = tag;
    expq.push_back(x);
    bp[n] += 2;
  endtask

  task automatic expect_pair(int n, bit data, string tag);
    expect_fetch(n, data ? 2 : 0, 0, tag);
    expect_fetch(n, data ? 3 : 1, 1, tag);
  endtask

  task automatic run_line(int v, int dup);
    vpos = 9'(v);
    for (int h = 0; h < LINE; h++) begin
      hpos = 9'(h);
      @(posedge clk); #1;
      if (h == dup) begin @(posedge clk); #1; end
    end
  endtask

  task automatic set_ptr(int n, bit hi, int val);
    vpos = 0; hpos = 0;
    ptr_wr = 1; ptr_wr_id = 3'(n); ptr_wr_hi = hi; ptr_wr_data = 16'(val);
    @(posedge clk); #1;
    ptr_wr = 0;
    if (hi) bp[n] = (bp[n] & 32'hFFFF) | ((val & 32'h1F) << 16);
    else    bp[n] = (bp[n] & ~32'hFFFF) | (val & 32'hFFFE);
  endtask

  task automatic end_phase(string tag);
    checks++;
    if (expq.size() != 0) begin
      failures++;
      $display("FAIL %s missing loads=%0d, expected 0", tag, expq.size());
    end
    expq.delete(); addrq.delete();
  endtask

  task automatic check_req(string tag, int exp_n);
    checks++;
    if (req_cnt != exp_n) begin
      failures++;
      $display("FAIL %s requests=%0d, expected %0d", tag, req_cnt, exp_n);
    end
    req_cnt = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired, expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 8; i++) bp[i] = 0;
    // sprite 0 list at word 0
    mem[0] = 16'h7E06; mem[1] = 16'hC008;
    mem[2] = 16'hA001; mem[3] = 16'hA002; mem[4] = 16'hA003; mem[5] = 16'hA004;
    mem[6] = 16'h3008; mem[7] = 16'h000A;
    mem[8] = 16'hB001; mem[9] = 16'hB002;
    mem[10] = 16'hFE00; mem[11] = 16'h0600;
    mem[32*3] = 16'h5555;
    mem[16'h140] = 16'h1234;

    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    checks++;
    if (mem_req !== 1'b0 || load_valid !== 1'b0 || slot_clash !== 1'b0) begin
      failures++;
      $display("FAIL R10 req=%b load=%b clash=%b, expected 0 0 0", mem_req, load_valid, slot_clash);
    end
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (mem_req !== 1'b0 || load_valid !== 1'b0) begin
      failures++;
      $display("FAIL R10 after reset req=%b load=%b, expected 0 0", mem_req, load_valid);
    end
    @(posedge clk); #1;

    // frame 1: start/stop, restart, pointer bit 0
    for (int n = 0; n < 8; n++) set_ptr(n, 0, (n == 1) ? 16'h0041 : n * 16'h40);
    req_cnt = 0;
    cur_req = "R3";
    for (int v = 0; v < 4; v++) run_line(v, -1);
    check_req("R3", 0);
    for (int n = 0; n < 8; n++) expect_pair(n, 0, "R4");
    expect_pair(0, 1, "R5");
    expect_pair(0, 1, "R4");
    expect_pair(0, 0, "R4");
    expect_pair(0, 1, "R6");
    expect_pair(0, 0, "R8");
    cur_req = "R7";
    for (int v = 4; v <= 12; v++) run_line(v, -1);
    end_phase("R7");
    req_cnt = 0;

    // frame 2: last-line flag
    for (int n = 0; n < 8; n++) set_ptr(n, 0, 16'h0200 + n * 16'h40);
    req_cnt = 0;
    cur_req = "R3";
    for (int v = 0; v <= 6; v++) begin
      last_line = (v == 4 || v == 5);
      run_line(v, -1);
    end
    last_line = 0;
    check_req("R3", 0);
    end_phase("R3");

    // frame 3: DMA disabled
    dma_en = 0;
    cur_req = "R2";
    for (int v = 0; v <= 6; v++) run_line(v, -1);
    check_req("R2", 0);
    end_phase("R2");
    dma_en = 1;

    // frame 4: horizontal limit cuts sprite 1 after its first fetch
    set_ptr(1, 1, 1);
    set_ptr(1, 0, 16'h0280);
    req_cnt = 0;
    fetch_limit = 9'd28;
    expect_pair(0, 0, "R2");
    expect_fetch(1, 0, 0, "R2");
    cur_req = "R2";
    for (int v = 0; v <= 5; v++) run_line(v, -1);
    check_req("R2", 3);
    end_phase("R2");
    fetch_limit = 9'd300;

    // frame 5: memory refuses, then same pointers reused
    cur_req = "R9";
    for (int v = 0; v <= 5; v++) begin
      mem_ready = (v != 4);
      run_line(v, -1);
    end
    mem_ready = 1;
    check_req("R9", 16);
    end_phase("R9");
    for (int n = 0; n < 8; n++) expect_pair(n, 0, "R9");
    for (int v = 0; v <= 5; v++) run_line(v, -1);
    check_req("R9", 16);
    end_phase("R9");

    // frame 6: beam stalls on a decision cycle, forcing a pipeline collision
    checks++;
    if (stray_clash != 0) begin
      failures++;
      $display("FAIL R11 stray clash pulses=%0d, expected 0", stray_clash);
    end
    ignore = 1; clash_ok = 1;
    for (int v = 0; v <= 4; v++) run_line(v, (v == 4) ? FIRST - 3 : -1);
    clash_ok = 0;
    checks++;
    if (clash_seen == 0) begin
      failures++;
      $display("FAIL R11 clash pulses=%0d, expected >0", clash_seen);
    end

    summary();
    $finish;
  end
endmodule